// File: doc/BRIEF.md
# Crypto Core Command Segment Parser

This block is the input side of a multi-mode cryptographic core. It reads 16-bit words from a public data port and decodes them as a stream of instructions and segments. A segment consists of a header word, two length words and then a payload. The parser passes each payload word straight through to the datapath. With every word it gives a byte-valid mask, a last-word mark and the index of the word within its segment. It also reports a one-cycle summary of each segment: type, last-of-type flag, last-of-message flag and byte length.

An encryption or decryption command is followed by its segments. For encryption these are an IV, associated data and the message. For decryption they are an IV, associated data, ciphertext and a tag. The parser does not enforce this order; it simply follows the headers until one marks the end of the message. Key material arrives on a separate secret port and is written to the datapath as it arrives. The key only takes effect when an activate-key instruction arrives on the public port, and only if a full key has been loaded since the last activation. Malformed instructions raise an error pulse, and parsing resumes with the next word.

Top module: `csp_parser`

## Requirements
- R1: After reset, the block is waiting for an instruction word, and none of out_valid, seg_valid, cmd_start, key_act and err is asserted.
- R2: An instruction word carries the message ID in bits 15:8, an opcode in bits 7:4 and a nibble in bits 3:0 that must be zero. Opcode 2 (encrypt) or 3 (decrypt) produces a one-cycle cmd_start in the cycle after the word is taken, with cmd_id set to the ID and cmd_dec set to 1 for opcode 3.
- R3: An instruction with a nonzero low nibble, or with an opcode other than 1, 2 or 3, gives a one-cycle err pulse in the cycle after it is taken. The next word is then decoded as an instruction.
- R4: After a command, each segment starts with a header word: ID in 15:8, type in 7:4, last-of-type in bit 3, last-of-message in bit 2, pad in bit 1, reserved in bit 0. Two length words follow, upper half first. In the cycle after the second length word is taken, seg_valid pulses for one cycle with the type, both flags and the 32-bit byte length.
- R5: A segment of L bytes delivers exactly ceil(L/2) payload words on out_data, each equal to the public input word, and out_valid is asserted only while payload is expected.
- R6: Every payload word has out_bmask = 2'b11, except the final word of an odd-length segment, which has 2'b10 (upper byte only). out_last is set on the final word only.
- R7: A zero-length segment still pulses seg_valid but delivers no payload words, and the next word is taken as the following header.
- R8: Once the payload of a segment with last-of-message set is complete, the next word is decoded as an instruction; otherwise it is decoded as a header.
- R9: While out_valid is high and out_accept is low, pub_take stays low and the payload word is held.
- R10: The secret port accepts at most KEY_WORDS words (default 8) between activations. Once that many are loaded, sec_take stays low.
- R11: An activate-key instruction (opcode 1) with a full key loaded gives a one-cycle key_act in the cycle after it and clears the key count. Without a full key it gives err and no key_act.
- R12: out_cnt gives the zero-based index of the current payload word within its segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pub_data | input | 16 | Public input word |
| pub_avail | input | 1 | Public word present |
| pub_take | output | 1 | Public word consumed this cycle |
| sec_data | input | 16 | Secret (key) input word |
| sec_avail | input | 1 | Secret word present |
| sec_take | output | 1 | Secret word consumed this cycle |
| key_wr | output | 1 | Key word write strobe to datapath |
| key_data | output | 16 | Key word to datapath |
| key_act | output | 1 | Loaded key becomes active |
| cmd_start | output | 1 | Encrypt/decrypt command decoded |
| cmd_dec | output | 1 | Command is a decryption |
| cmd_id | output | 8 | Message ID of the command |
| seg_valid | output | 1 | Segment summary pulse |
| seg_type | output | 4 | Segment type |
| seg_last_type | output | 1 | Last segment of this type |
| seg_last_msg | output | 1 | Last segment of the message |
| seg_len | output | 32 | Segment length in bytes |
| out_data | output | 16 | Payload word |
| out_valid | output | 1 | Payload word present |
| out_accept | input | 1 | Datapath accepts payload word |
| out_bmask | output | 2 | Byte-valid mask, bit 1 = upper byte |
| out_last | output | 1 | Final payload word of segment |
| out_cnt | output | 32 | Index of payload word in segment |
| err | output | 1 | Malformed instruction or premature key activation |

## Verification
The properties assume a well-behaved source: a public word, once offered, stays unchanged with pub_avail high until pub_take, and headers follow commands in the framing described, so that the stream never becomes misaligned. They also take for granted that out_accept alone decides whether the datapath takes a payload word. The bench drives the ports only through tasks that hold each word until it is consumed, and it builds every header and length pair from the same fields it records as expected. Backpressure comes from a fixed accept pattern that leaves one cycle in three stalled, applied during the decryption command.

// File: rtl/csp_pkg.sv
package csp_pkg;

   typedef enum logic [2:0] {
      ST_INSTR,
      ST_HDR,
      ST_LENH,
      ST_LENL,
      ST_DATA
   } csp_state_e;

   localparam logic [3:0] OP_KEY_ACT = 4'h1;
   localparam logic [3:0] OP_ENCRYPT = 4'h2;
   localparam logic [3:0] OP_DECRYPT = 4'h3;

   localparam logic [1:0] MASK_BOTH  = 2'b11;
   localparam logic [1:0] MASK_UPPER = 2'b10;

endpackage

// File: rtl/csp_len_ctr.sv
module csp_len_ctr #(
   parameter int LEN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] byte_len,
   input  logic             step,
   output logic             last,
   output logic             odd,
   output logic [LEN_W-1:0] idx
);
   logic [LEN_W-1:0] rem_q;
   logic [LEN_W-1:0] words;

   assign words = (byte_len >> 1) + LEN_W'(byte_len[0]);
   assign last  = (rem_q == LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         idx   <= '0;
         odd   <= 1'b0;
      end else if (load) begin
         rem_q <= words;
         idx   <= '0;
         odd   <= byte_len[0];
      end else if (step) begin
         rem_q <= rem_q - LEN_W'(1);
         idx   <= idx + LEN_W'(1);
      end
   end
endmodule

// File: rtl/csp_key_gate.sv
module csp_key_gate #(
   parameter int KEY_WORDS = 8,
   parameter bit KEY_CHECK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_avail,
   input  logic act_req,
   output logic sec_take,
   output logic key_wr,
   output logic key_act,
   output logic act_fail
);
   localparam int CNT_W = $clog2(KEY_WORDS + 1);

   assign key_wr = sec_avail & sec_take;

   generate
      if (KEY_CHECK) begin : g_gated
         logic [CNT_W-1:0] cnt_q;
         logic             full;

         assign full     = (cnt_q == CNT_W'(KEY_WORDS));
         assign sec_take = sec_avail & ~full;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q    <= '0;
               key_act  <= 1'b0;
               act_fail <= 1'b0;
            end else begin
               key_act  <= act_req & full;
               act_fail <= act_req & ~full;
               if (act_req && full)
                  cnt_q <= '0;
               else if (key_wr)
                  cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end else begin : g_open
         assign sec_take = sec_avail;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               key_act  <= 1'b0;
               act_fail <= 1'b0;
            end else begin
               key_act  <= act_req;
               act_fail <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/csp_parser.sv
module csp_parser
   import csp_pkg::*;
#(
   parameter  int DATA_W    = 16,
   parameter  int KEY_WORDS = 8,
   parameter  bit KEY_CHECK = 1'b1,
   localparam int LEN_W     = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pub_data,
   input  logic              pub_avail,
   output logic              pub_take,
   input  logic [DATA_W-1:0] sec_data,
   input  logic              sec_avail,
   output logic              sec_take,
   output logic              key_wr,
   output logic [DATA_W-1:0] key_data,
   output logic              key_act,
   output logic              cmd_start,
   output logic              cmd_dec,
   output logic [7:0]        cmd_id,
   output logic              seg_valid,
   output logic [3:0]        seg_type,
   output logic              seg_last_type,
   output logic              seg_last_msg,
   output logic [LEN_W-1:0]  seg_len,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   input  logic              out_accept,
   output logic [1:0]        out_bmask,
   output logic              out_last,
   output logic [LEN_W-1:0]  out_cnt,
   output logic              err
);
   generate
      if (DATA_W != 16) begin : g_bad_width
         $error("csp_parser: word framing is defined for 16-bit words only");
      end
      if (KEY_WORDS < 1) begin : g_bad_key
         $error("csp_parser: KEY_WORDS must be at least 1");
      end
   endgenerate

   csp_state_e        state_q;
   logic [DATA_W-1:0] len_hi_q;
   logic              err_q;
   logic              act_fail;
   logic [3:0]        opcode;
   logic              instr_bad;
   logic              act_req;
   logic              cnt_load;
   logic              cnt_step;
   logic              cnt_last;
   logic              cnt_odd;
   logic [LEN_W-1:0]  full_len;

   assign opcode    = pub_data[7:4];
   assign instr_bad = (pub_data[3:0] != 4'h0) ||
                      !(opcode == OP_KEY_ACT || opcode == OP_ENCRYPT || opcode == OP_DECRYPT);
   assign full_len  = {len_hi_q, pub_data};

   assign out_valid = (state_q == ST_DATA) & pub_avail;
   assign out_data  = pub_data;
   assign pub_take  = pub_avail & ((state_q != ST_DATA) | out_accept);
   assign out_last  = (state_q == ST_DATA) & cnt_last;
   assign out_bmask = (out_last && cnt_odd) ? MASK_UPPER : MASK_BOTH;

   assign act_req  = pub_take && (state_q == ST_INSTR) && !instr_bad && (opcode == OP_KEY_ACT);
   assign cnt_load = pub_take && (state_q == ST_LENL);
   assign cnt_step = pub_take && (state_q == ST_DATA);
   assign err      = err_q | act_fail;
   assign key_data = sec_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_INSTR;
         len_hi_q      <= '0;
         err_q         <= 1'b0;
         cmd_start     <= 1'b0;
         cmd_dec       <= 1'b0;
         cmd_id        <= '0;
         seg_valid     <= 1'b0;
         seg_type      <= '0;
         seg_last_type <= 1'b0;
         seg_last_msg  <= 1'b0;
         seg_len       <= '0;
      end else begin
         err_q     <= 1'b0;
         cmd_start <= 1'b0;
         seg_valid <= 1'b0;
         if (pub_take) begin
            unique case (state_q)
               ST_INSTR: begin
                  if (instr_bad) begin
                     err_q <= 1'b1;
                  end else if (opcode != OP_KEY_ACT) begin
                     cmd_start <= 1'b1;
                     cmd_dec   <= (opcode == OP_DECRYPT);
                     cmd_id    <= pub_data[15:8];
                     state_q   <= ST_HDR;
                  end
               end
               ST_HDR: begin
                  seg_type      <= pub_data[7:4];
                  seg_last_type <= pub_data[3];
                  seg_last_msg  <= pub_data[2];
                  state_q       <= ST_LENH;
               end
               ST_LENH: begin
                  len_hi_q <= pub_data;
                  state_q  <= ST_LENL;
               end
               ST_LENL: begin
                  seg_valid <= 1'b1;
                  seg_len   <= full_len;
                  if (full_len != '0)
                     state_q <= ST_DATA;
                  else
                     state_q <= seg_last_msg ? ST_INSTR : ST_HDR;
               end
               ST_DATA: begin
                  if (cnt_last)
                     state_q <= seg_last_msg ? ST_INSTR : ST_HDR;
               end
               default: state_q <= ST_INSTR;
            endcase
         end
      end
   end

   csp_len_ctr #(.LEN_W(LEN_W)) u_len_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .byte_len (full_len),
      .step     (cnt_step),
      .last     (cnt_last),
      .odd      (cnt_odd),
      .idx      (out_cnt)
   );

   csp_key_gate #(.KEY_WORDS(KEY_WORDS), .KEY_CHECK(KEY_CHECK)) u_key_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_avail (sec_avail),
      .act_req   (act_req),
      .sec_take  (sec_take),
      .key_wr    (key_wr),
      .key_act   (key_act),
      .act_fail  (act_fail)
   );
endmodule

// File: rtl/csp_parser_chk.sv
module csp_parser_chk #(
   parameter int DATA_W    = 16,
   parameter int KEY_WORDS = 8,
   parameter bit KEY_CHECK = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                pub_avail,
   input logic                pub_take,
   input logic                sec_take,
   input logic                key_wr,
   input logic                key_act,
   input logic                cmd_start,
   input logic                err,
   input logic                out_valid,
   input logic                out_accept,
   input logic [1:0]          out_bmask,
   input logic                out_last,
   input logic [2*DATA_W-1:0] out_cnt
);
   // R9: a stalled payload word is not consumed
   a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_accept) |-> !pub_take);

   // R5: payload is only offered when the source has a word
   a_r5_valid_from_source: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> pub_avail);

   // R6: words before the last always carry both bytes
   a_r6_full_mask_midseg: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> (out_bmask == 2'b11));

   // R12: index advances by one per accepted non-final word
   a_r12_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_accept && !out_last) |=> (out_cnt == $past(out_cnt) + (2*DATA_W)'(1)));

   // R2: an instruction has at most one outcome per cycle
   a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_start, key_act, err}));

   // R11: activation and rejection exclude each other
   a_r11_act_not_err: assert property (@(posedge clk) disable iff (!rst_n)
      !(key_act && err));

   generate
      if (KEY_CHECK) begin : g_key_bound
         int kcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               kcnt <= 0;
            else if (key_act)
               kcnt <= key_wr ? 1 : 0;
            else if (key_wr)
               kcnt <= kcnt + 1;
         end
         // R10: no key word accepted beyond the key size
         a_r10_key_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (kcnt == KEY_WORDS && !key_act) |-> !sec_take);
      end
   endgenerate
endmodule

bind csp_parser csp_parser_chk #(
   .DATA_W    (DATA_W),
   .KEY_WORDS (KEY_WORDS),
   .KEY_CHECK (KEY_CHECK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pub_avail  (pub_avail),
   .pub_take   (pub_take),
   .sec_take   (sec_take),
   .key_wr     (key_wr),
   .key_act    (key_act),
   .cmd_start  (cmd_start),
   .err        (err),
   .out_valid  (out_valid),
   .out_accept (out_accept),
   .out_bmask  (out_bmask),
   .out_last   (out_last),
   .out_cnt    (out_cnt)
);

// File: tb/csp_parser_bench.sv
module csp_parser_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pub_data = '0;
   logic        pub_avail = 1'b0;
   logic        pub_take;
   logic [15:0] sec_data = '0;
   logic        sec_avail = 1'b0;
   logic        sec_take, key_wr, key_act;
   logic [15:0] key_data;
   logic        cmd_start, cmd_dec;
   logic [7:0]  cmd_id;
   logic        seg_valid, seg_last_type, seg_last_msg;
   logic [3:0]  seg_type;
   logic [31:0] seg_len;
   logic [15:0] out_data;
   logic        out_valid;
   logic        out_accept = 1'b1;
   logic [1:0]  out_bmask;
   logic        out_last;
   logic [31:0] out_cnt;
   logic        err;

   always #5 clk = ~clk;

   csp_parser u_csp_parser (
      .clk(clk), .rst_n(rst_n),
      .pub_data(pub_data), .pub_avail(pub_avail), .pub_take(pub_take),
      .sec_data(sec_data), .sec_avail(sec_avail), .sec_take(sec_take),
      .key_wr(key_wr), .key_data(key_data), .key_act(key_act),
      .cmd_start(cmd_start), .cmd_dec(cmd_dec), .cmd_id(cmd_id),
      .seg_valid(seg_valid), .seg_type(seg_type), .seg_last_type(seg_last_type),
      .seg_last_msg(seg_last_msg), .seg_len(seg_len),
      .out_data(out_data), .out_valid(out_valid), .out_accept(out_accept),
      .out_bmask(out_bmask), .out_last(out_last), .out_cnt(out_cnt), .err(err)
   );

   int n_run = 0;
   int n_fail = 0;
   int n_err = 0;
   int n_act = 0;
   int cyc = 0;
   bit stall_mode = 1'b0;

   // payload item: data, mask, last, index
   logic [34:0] pay_q[$];
   // segment item: type, last_type, last_msg, length
   logic [37:0] seg_q[$];
   // command item: id, decrypt
   logic [8:0]  cmd_q[$];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // accept pattern: one cycle in three stalled when enabled
   always @(posedge clk) begin
      cyc <= cyc + 1;
      #2 out_accept = stall_mode ? ((cyc % 3) != 2) : 1'b1;
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      logic [34:0] pe;
      logic [37:0] se;
      logic [8:0]  ce;
      if (rst_n) begin
         if (seg_valid) begin
            if (seg_q.size() == 0) chk(1'b0, "R4 unexpected seg_valid", 1, 0);
            else begin
               se = seg_q.pop_front();
               chk({seg_type, seg_last_type, seg_last_msg, seg_len} == se, "R4 segment summary",
                   {seg_type, seg_last_type, seg_last_msg, seg_len}, se);
            end
         end
         if (out_valid && out_accept) begin
            if (pay_q.size() == 0) chk(1'b0, "R5 unexpected payload word", out_data, 0);
            else begin
               pe = pay_q.pop_front();
               chk(out_data == pe[34:19], "R5 payload data", out_data, pe[34:19]);
               chk(out_bmask == pe[18:17], "R6 byte mask", out_bmask, pe[18:17]);
               chk(out_last == pe[16], "R6 last flag", out_last, pe[16]);
               chk(out_cnt == {16'h0, pe[15:0]}, "R12 word index", out_cnt, pe[15:0]);
            end
         end
         if (out_valid && !out_accept)
            chk(!pub_take, "R9 stall holds word", pub_take, 0);
         if (cmd_start) begin
            if (cmd_q.size() == 0) chk(1'b0, "R2 unexpected cmd_start", cmd_id, 0);
            else begin
               ce = cmd_q.pop_front();
               chk({cmd_id, cmd_dec} == ce, "R2 command decode", {cmd_id, cmd_dec}, ce);
            end
         end
         if (err) n_err++;
         if (key_act) n_act++;
      end
   end

   task automatic send_pub(input logic [15:0] w);
      pub_data  = w;
      pub_avail = 1'b1;
      do @(negedge clk); while (!pub_take);
      @(posedge clk);
      #2 pub_avail = 1'b0;
   endtask

   task automatic send_sec(input logic [15:0] w);
      sec_data  = w;
      sec_avail = 1'b1;
      do @(negedge clk); while (!sec_take);
      @(posedge clk);
      #2 sec_avail = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic send_seg(input logic [7:0] id, input logic [3:0] typ, input bit lt,
                           input bit lm, input logic [31:0] len, input logic [15:0] base);
      int nw;
      nw = int'((len >> 1) + {31'h0, len[0]});
      seg_q.push_back({typ, lt, lm, len});
      send_pub({id, typ, lt, lm, 2'b00});
      send_pub(len[31:16]);
      send_pub(len[15:0]);
      for (int i = 0; i < nw; i++) begin
         logic [15:0] d;
         bit          lst;
         d   = base + 16'(i * 16'h0101);
         lst = (i == nw - 1);
         pay_q.push_back({d, (lst && len[0]) ? 2'b10 : 2'b11, lst, 16'(i)});
         send_pub(d);
      end
   endtask

   task automatic run_all();
      idle(3);
      rst_n = 1'b1;
      idle(1);
      @(negedge clk);
      // R1: reset state
      chk(!out_valid && !seg_valid && !cmd_start && !key_act && !err, "R1 reset outputs quiet",
          {out_valid, seg_valid, cmd_start, key_act, err}, 0);
      idle(1);

      // R11: activation without a loaded key is rejected
      send_pub({8'h10, 4'h1, 4'h0});
      idle(3);
      chk(n_err == 1, "R11 activate without key gives err", n_err, 1);
      chk(n_act == 0, "R11 activate without key no key_act", n_act, 0);

      // R3: reserved nibble nonzero, then unknown opcode
      send_pub({8'h11, 4'h2, 4'h5});
      idle(3);
      chk(n_err == 2, "R3 reserved nibble error", n_err, 2);
      send_pub({8'h12, 4'h9, 4'h0});
      idle(3);
      chk(n_err == 3, "R3 unknown opcode error", n_err, 3);

      // R2/R4/R5/R6: encryption command, next word after error is an instruction
      cmd_q.push_back({8'h21, 1'b0});
      send_pub({8'h21, 4'h2, 4'h0});
      send_seg(8'h21, 4'h1, 1'b1, 1'b0, 32'd12, 16'h1000);
      send_seg(8'h21, 4'h2, 1'b1, 1'b0, 32'd5,  16'h2000);
      send_seg(8'h21, 4'h4, 1'b1, 1'b1, 32'd7,  16'h3000);
      idle(3);
      chk(pay_q.size() == 0, "R5 all encrypt payload seen", pay_q.size(), 0);
      chk(seg_q.size() == 0, "R4 all encrypt segments seen", seg_q.size(), 0);
      chk(cmd_q.size() == 0, "R2 encrypt command seen", cmd_q.size(), 0);

      // R10: load a full key, then the secret port closes
      for (int k = 0; k < 8; k++) send_sec(16'hA000 + 16'(k));
      sec_data  = 16'hBEEF;
      sec_avail = 1'b1;
      idle(3);
      @(negedge clk);
      chk(!sec_take, "R10 secret port closed when full", sec_take, 0);
      chk(!key_wr, "R10 no key write beyond key size", key_wr, 0);
      idle(1);
      sec_avail = 1'b0;

      // R8/R11: after last-of-message, activate is decoded as an instruction
      send_pub({8'h13, 4'h1, 4'h0});
      idle(3);
      chk(n_act == 1, "R11 activate with full key", n_act, 1);
      chk(n_err == 3, "R8 word after message decoded as instruction", n_err, 3);
      sec_data  = 16'hC001;
      sec_avail = 1'b1;
      @(negedge clk);
      chk(sec_take, "R11 key count cleared on activation", sec_take, 1);
      @(posedge clk);
      #2 sec_avail = 1'b0;

      // R7/R9: decryption with backpressure and a zero-length segment
      stall_mode = 1'b1;
      cmd_q.push_back({8'h22, 1'b1});
      send_pub({8'h22, 4'h3, 4'h0});
      send_seg(8'h22, 4'h1, 1'b1, 1'b0, 32'd12, 16'h4000);
      send_seg(8'h22, 4'h2, 1'b1, 1'b0, 32'd0,  16'h5000);
      send_seg(8'h22, 4'h5, 1'b1, 1'b0, 32'd3,  16'h6000);
      send_seg(8'h22, 4'h6, 1'b1, 1'b1, 32'd16, 16'h7000);
      idle(3);
      stall_mode = 1'b0;
      chk(pay_q.size() == 0, "R7 all decrypt payload seen", pay_q.size(), 0);
      chk(seg_q.size() == 0, "R7 zero-length segment reported", seg_q.size(), 0);
      chk(cmd_q.size() == 0, "R2 decrypt command seen", cmd_q.size(), 0);

      // R8: after the tag, an unknown opcode is treated as an instruction
      send_pub({8'h14, 4'hF, 4'h0});
      idle(3);
      chk(n_err == 4, "R8 instruction after decrypt message", n_err, 4);
      chk(n_act == 1, "R11 no stray key_act", n_act, 1);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog R1-all actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule